// File: doc/BRIEF.md
# Audio Link Outgoing Frame Builder

This block lives on the controller side of a five-wire time-division audio link. The codec supplies the bit clock. On every rising bit-clock edge the block drives two outputs: the frame marker (SYNC) and one serial data bit. The receiver samples that bit on the falling edge. A frame lasts 256 bit clocks. It holds a 16-bit tag field followed by twelve 20-bit slots, and the tag field says which slots carry meaningful content.

A parallel interface presents six payloads, each with its own valid flag:

- command address
- command data
- left playback sample
- right playback sample
- two S/PDIF channels

The block copies all payloads and flags into a shadow store on the edge that opens a frame. It derives the tag field from the flags and zeroes every slot whose flag is clear. It then sends the frame most significant bit first. Serial data trails the frame marker by one bit clock. Upstream logic may therefore change its payloads at any time, and the frame already in progress is unaffected.

Top module: `aclink_out_framer`

## Requirements
- R1: While `rst_n` is low, `sync_o` and `sdata_o` are both 0.
- R2: The first rising `bit_clk` edge after reset release raises `sync_o`. After that, `sync_o` is high for exactly 16 consecutive bit clocks in every 256.
- R3: Tag bit 15, the first bit sent, is 1 exactly when at least one payload flag is set. Tag bits 14 down to 3 report slots 1 to 12 in that order, with 1 meaning valid. Tag bits 2 to 0 are 0.
- R4: The payloads map to fixed slots:
  - slot 1: command address
  - slot 2: command data
  - slot 3: left sample
  - slot 4: right sample
  - slot 10: S/PDIF channel A
  - slot 11: S/PDIF channel B
  
  Slots 5 to 9 and slot 12 are always tagged invalid.
- R5: Every bit of a slot tagged invalid is sent as 0.
- R6: Every slot is sent MSB first. A playback sample of `SAMPLE_W` bits (default 18) fills the top bits of its 20-bit slot, and the low `20-SAMPLE_W` bits are 0.
- R7: Serial data lags the frame marker by one bit clock. On the edge that raises `sync_o`, `sdata_o` carries the last bit of the previous frame. Tag bit 15 follows on the next edge.
- R8: Payloads and flags are sampled only on the edge that raises `sync_o`. Changes at any other time do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_addr_i | input | 20 | Command address slot payload |
| cmd_addr_vld_i | input | 1 | Command address valid flag |
| cmd_data_i | input | 20 | Command data slot payload |
| cmd_data_vld_i | input | 1 | Command data valid flag |
| pcm_left_i | input | SAMPLE_W | Left playback sample |
| pcm_left_vld_i | input | 1 | Left sample valid flag |
| pcm_right_i | input | SAMPLE_W | Right playback sample |
| pcm_right_vld_i | input | 1 | Right sample valid flag |
| spdif_a_i | input | 20 | S/PDIF channel A payload |
| spdif_a_vld_i | input | 1 | Channel A valid flag |
| spdif_b_i | input | 20 | S/PDIF channel B payload |
| spdif_b_vld_i | input | 1 | Channel B valid flag |
| sync_o | output | 1 | Frame marker, high during the tag phase |
| sdata_o | output | 1 | Outgoing serial data |

## Verification
A slipped frame counter shows at `sync_o` within one frame: the high pulse would be wider or narrower than 16 clocks, or the next rising edge would arrive away from 256 clocks after the last one. A wrong position-to-slot decode puts tag or payload bits into the wrong slot in the very next frame. Corrupt shadow contents show the same way, as nonzero bits in slots tagged invalid. A capture on the wrong edge lets a mid-frame payload change leak into the frame being sent. Each of these faults is therefore visible in the first whole frame captured after the fault occurs.

// File: rtl/aclink_pkg.sv
`timescale 1ns/1ps
package aclink_pkg;
  localparam int SLOT_W     = 20;
  localparam int TAG_W      = 16;
  localparam int NUM_SLOTS  = 12;
  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int SEL_W      = $clog2(NUM_SLOTS + 1);
  localparam int BIT_W      = $clog2(SLOT_W);

  // slot numbers used by the payload map (slot 0 is the tag field)
  localparam int SLOT_CMD_ADDR = 1;
  localparam int SLOT_CMD_DATA = 2;
  localparam int SLOT_PCM_L    = 3;
  localparam int SLOT_PCM_R    = 4;
  localparam int SLOT_SPDIF_A  = 10;
  localparam int SLOT_SPDIF_B  = 11;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [CNT_W-1:0]  pos_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [BIT_W-1:0]  bidx_t;

  // which slot a frame position belongs to; 0 means the tag field
  function automatic sel_t slot_at(pos_t pos);
    int p;
    p = int'(pos);
    if (p < TAG_W) return '0;
    return sel_t'((p - TAG_W) / SLOT_W + 1);
  endfunction

  // bit index inside that slot, counting down so MSB goes first
  function automatic bidx_t bit_at(pos_t pos);
    int p;
    p = int'(pos);
    if (p < TAG_W) return bidx_t'(TAG_W - 1 - p);
    return bidx_t'(SLOT_W - 1 - ((p - TAG_W) % SLOT_W));
  endfunction

  // tag bit that reports a given slot number
  function automatic int tag_bit_for(int slot);
    return TAG_W - 1 - slot;
  endfunction

  // place a narrower sample at the top of a slot
  function automatic slot_t justify(slot_t raw, int width);
    return raw << (SLOT_W - width);
  endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
`timescale 1ns/1ps
module aclink_frame_timer
  import aclink_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output pos_t cnt_o,
  output logic frame_start_o,
  output logic sync_o
);
  pos_t cnt_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == pos_t'(FRAME_BITS - 1)) ? '0 : cnt_q + 1'b1;
      sync_q <= int'(cnt_q) < TAG_W;
    end
  end

  assign cnt_o         = cnt_q;
  assign frame_start_o = (cnt_q == '0);
  assign sync_o        = sync_q;

  // R2: marker rises one edge into the frame and falls after 16 clocks
  p_sync_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> cnt_q == pos_t'(1));
  p_sync_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_q) |-> cnt_q == pos_t'(TAG_W + 1));
endmodule

// File: rtl/aclink_slot_shadow.sv
`timescale 1ns/1ps
module aclink_slot_shadow
  import aclink_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             capture_i,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0] raw_i,
  input  logic [NUM_SLOTS-1:0]             vld_i,
  output logic [TAG_W-1:0]                 tag_o,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_o
);
  localparam int SPARE_W = TAG_W - 1 - NUM_SLOTS;

  logic [NUM_SLOTS-1:0][SLOT_W-1:0] gated;
  logic [TAG_W-1:0]                 tag_next;

  assign tag_next[TAG_W-1]     = |vld_i;
  assign tag_next[SPARE_W-1:0] = '0;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign gated[g]                      = vld_i[g] ? raw_i[g] : '0;
    assign tag_next[tag_bit_for(g + 1)]  = vld_i[g];

    // R5: a slot whose tag bit is clear holds nothing but zeros
    p_invalid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tag_o[tag_bit_for(g + 1)] |-> slot_o[g] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_o  <= '0;
      slot_o <= '0;
    end else if (capture_i) begin
      tag_o  <= tag_next;
      slot_o <= gated;
    end
  end

  // R3: frame-valid bit agrees with the per-slot tag bits
  p_frame_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tag_o[TAG_W-1] == (|tag_o[TAG_W-2:SPARE_W]));
  // R8: the shadow only moves on a capture edge
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(slot_o) && $stable(tag_o));
endmodule

// File: rtl/aclink_bit_mux.sv
`timescale 1ns/1ps
module aclink_bit_mux
  import aclink_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  pos_t                             cnt_i,
  input  logic [TAG_W-1:0]                 tag_i,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_i,
  output logic                             sdata_o
);
  pos_t  pos;
  sel_t  slot_n;
  bidx_t bit_n;
  sel_t  slot_idx;
  logic  bit_now;

  // one position behind the counter: data trails the marker by a clock
  always_comb begin
    pos      = (cnt_i == '0) ? pos_t'(FRAME_BITS - 1) : cnt_i - 1'b1;
    slot_n   = slot_at(pos);
    bit_n    = bit_at(pos);
    slot_idx = slot_n - 1'b1;
    if (slot_n == '0) bit_now = tag_i[bit_n[$clog2(TAG_W)-1:0]];
    else              bit_now = slot_i[slot_idx][bit_n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdata_o <= 1'b0;
    else        sdata_o <= bit_now;
  end
endmodule

// File: rtl/aclink_out_framer.sv
`timescale 1ns/1ps
module aclink_out_framer
  import aclink_pkg::*;
#(
  parameter int SAMPLE_W = 18
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic [SLOT_W-1:0]   cmd_addr_i,
  input  logic                cmd_addr_vld_i,
  input  logic [SLOT_W-1:0]   cmd_data_i,
  input  logic                cmd_data_vld_i,
  input  logic [SAMPLE_W-1:0] pcm_left_i,
  input  logic                pcm_left_vld_i,
  input  logic [SAMPLE_W-1:0] pcm_right_i,
  input  logic                pcm_right_vld_i,
  input  logic [SLOT_W-1:0]   spdif_a_i,
  input  logic                spdif_a_vld_i,
  input  logic [SLOT_W-1:0]   spdif_b_i,
  input  logic                spdif_b_vld_i,
  output logic                sync_o,
  output logic                sdata_o
);
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] raw;
  logic [NUM_SLOTS-1:0]             vld;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] shadow_slots;
  logic [TAG_W-1:0]                 shadow_tag;
  pos_t                             frame_pos;
  logic                             frame_start;

  // payload map, one branch per slot number
  for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_map
    if (s == SLOT_CMD_ADDR) begin : g_addr
      assign raw[s-1] = cmd_addr_i;
      assign vld[s-1] = cmd_addr_vld_i;
    end else if (s == SLOT_CMD_DATA) begin : g_data
      assign raw[s-1] = cmd_data_i;
      assign vld[s-1] = cmd_data_vld_i;
    end else if (s == SLOT_PCM_L) begin : g_pcm_l
      assign raw[s-1] = justify(slot_t'(pcm_left_i), SAMPLE_W);
      assign vld[s-1] = pcm_left_vld_i;
    end else if (s == SLOT_PCM_R) begin : g_pcm_r
      assign raw[s-1] = justify(slot_t'(pcm_right_i), SAMPLE_W);
      assign vld[s-1] = pcm_right_vld_i;
    end else if (s == SLOT_SPDIF_A) begin : g_spa
      assign raw[s-1] = spdif_a_i;
      assign vld[s-1] = spdif_a_vld_i;
    end else if (s == SLOT_SPDIF_B) begin : g_spb
      assign raw[s-1] = spdif_b_i;
      assign vld[s-1] = spdif_b_vld_i;
    end else begin : g_unused
      assign raw[s-1] = '0;
      assign vld[s-1] = 1'b0;
      // R4: unmapped slots never get tagged
      p_unused_slot_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !shadow_tag[tag_bit_for(s)]);
    end
  end

  aclink_frame_timer u_timer (
    .clk           (bit_clk),
    .rst_n         (rst_n),
    .cnt_o         (frame_pos),
    .frame_start_o (frame_start),
    .sync_o        (sync_o)
  );

  aclink_slot_shadow u_shadow (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .capture_i (frame_start),
    .raw_i     (raw),
    .vld_i     (vld),
    .tag_o     (shadow_tag),
    .slot_o    (shadow_slots)
  );

  aclink_bit_mux u_mux (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .cnt_i   (frame_pos),
    .tag_i   (shadow_tag),
    .slot_i  (shadow_slots),
    .sdata_o (sdata_o)
  );

  // R7: the first bit after the marker rises is the frame-valid tag bit
  p_lag_first_tag_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(sync_o) |=> sdata_o == shadow_tag[TAG_W-1]);
  // R3: spare tag bits stay low
  p_spare_tag_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    shadow_tag[TAG_W-2-NUM_SLOTS:0] == '0);
endmodule

// File: tb/aclink_out_framer_test.sv
`timescale 1ns/1ps
module aclink_out_framer_test;
  localparam int N = 6;
  // flag order {addr, data, left, right, spdif A, spdif B}
  localparam logic [5:0]  V_VLD  [N] = '{6'b000000, 6'b111111, 6'b110000, 6'b001100, 6'b000001, 6'b001010};
  localparam logic [15:0] V_TAG  [N] = '{16'h0000, 16'hF830, 16'hE000, 16'h9800, 16'h8010, 16'h9020};
  localparam logic [19:0] V_ADDR [N] = '{20'h8A5C0, 20'h12340, 20'hFFFFF, 20'h55555, 20'hAAAAA, 20'h0F0F0};
  localparam logic [19:0] V_DATA [N] = '{20'hFFFFF, 20'hBEEF1, 20'h00001, 20'h80000, 20'h3C3C3, 20'h7E7E7};
  localparam logic [17:0] V_PCML [N] = '{18'h3FFFF, 18'h20001, 18'h15555, 18'h2AAAA, 18'h00F0F, 18'h3FFFF};
  localparam logic [17:0] V_PCMR [N] = '{18'h12345, 18'h3FFFF, 18'h00001, 18'h20000, 18'h1FFFF, 18'h2D2D2};
  localparam logic [19:0] V_SPA  [N] = '{20'hFFFFF, 20'hC0FFE, 20'h11111, 20'h22222, 20'h33333, 20'hA0A0A};
  localparam logic [19:0] V_SPB  [N] = '{20'hFFFFF, 20'h0D00D, 20'h44444, 20'h88888, 20'hFEDCB, 20'h55AA5};

  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] cmd_addr, cmd_data, spa, spb;
  logic [17:0] pcml, pcmr;
  logic va, vd, vl, vr, vsa, vsb;
  logic sync, sdata;
  int n_checks = 0;
  int n_fail = 0;

  always #4 bit_clk = ~bit_clk;

  aclink_out_framer uut (
    .bit_clk(bit_clk), .rst_n(rst_n),
    .cmd_addr_i(cmd_addr), .cmd_addr_vld_i(va),
    .cmd_data_i(cmd_data), .cmd_data_vld_i(vd),
    .pcm_left_i(pcml), .pcm_left_vld_i(vl),
    .pcm_right_i(pcmr), .pcm_right_vld_i(vr),
    .spdif_a_i(spa), .spdif_a_vld_i(vsa),
    .spdif_b_i(spb), .spdif_b_vld_i(vsb),
    .sync_o(sync), .sdata_o(sdata)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected frame built as a plain concatenation, tag first
  function automatic logic [255:0] exp_frame(int i);
    logic [19:0] s1, s2, s3, s4, s10, s11;
    logic [5:0] f;
    f   = V_VLD[i];
    s1  = f[5] ? V_ADDR[i] : 20'h0;
    s2  = f[4] ? V_DATA[i] : 20'h0;
    s3  = f[3] ? {V_PCML[i], 2'b00} : 20'h0;
    s4  = f[2] ? {V_PCMR[i], 2'b00} : 20'h0;
    s10 = f[1] ? V_SPA[i] : 20'h0;
    s11 = f[0] ? V_SPB[i] : 20'h0;
    return {|f, f[5], f[4], f[3], f[2], 5'b0, f[1], f[0], 1'b0, 3'b0,
            s1, s2, s3, s4, 100'h0, s10, s11, 20'h0};
  endfunction

  task automatic drive(int i, bit flip);
    cmd_addr = flip ? ~V_ADDR[i] : V_ADDR[i];
    cmd_data = flip ? ~V_DATA[i] : V_DATA[i];
    pcml     = flip ? ~V_PCML[i] : V_PCML[i];
    pcmr     = flip ? ~V_PCMR[i] : V_PCMR[i];
    spa      = flip ? ~V_SPA[i]  : V_SPA[i];
    spb      = flip ? ~V_SPB[i]  : V_SPB[i];
    {va, vd, vl, vr, vsa, vsb} = flip ? ~V_VLD[i] : V_VLD[i];
  endtask

  task automatic wait_rise();
    logic prev;
    prev = sync;
    @(negedge bit_clk);
    while (!(sync && !prev)) begin
      prev = sync;
      @(negedge bit_clk);
    end
  endtask

  // collect 256 bits starting the clock after the marker rose
  task automatic capture(output logic [255:0] cap, output int sync_err);
    sync_err = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge bit_clk);
      cap[255-k] = sdata;
      if (sync !== ((k < 15) || (k == 255))) sync_err++;
    end
  endtask

  task automatic check_frame(int i, logic [255:0] cap, int sync_err);
    logic [255:0] e;
    e = exp_frame(i);
    check(sync_err == 0, "R2", "marker width/period errors", 256'(sync_err), 256'h0);
    check(cap[255:240] == V_TAG[i], "R3", "tag field", 256'(cap[255:240]), 256'(V_TAG[i]));
    check({cap[239:200], cap[59:20]} == {e[239:200], e[59:20]}, "R4", "command and S/PDIF slots",
          256'({cap[239:200], cap[59:20]}), 256'({e[239:200], e[59:20]}));
    check(cap[199:160] == e[199:160], "R6", "playback slots", 256'(cap[199:160]), 256'(e[199:160]));
    check(cap == e, "R5", "whole frame incl. zeroed slots", cap, e);
    check(cap[255] == |V_VLD[i], "R7", "first bit after marker", 256'(cap[255]), 256'(|V_VLD[i]));
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "WDOG", "watchdog expired", 256'h0, 256'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] cap;
    int serr;
    drive(0, 1'b0);
    repeat (4) @(negedge bit_clk);
    // R1: quiet outputs while in reset
    check(sync == 1'b0 && sdata == 1'b0, "R1", "outputs in reset", 256'({sync, sdata}), 256'h0);
    rst_n = 1'b1;
    @(negedge bit_clk);
    // R2: first edge after release opens a frame
    check(sync == 1'b1, "R2", "marker after release", 256'(sync), 256'h1);

    for (int i = 0; i < N; i++) begin
      drive(i, 1'b0);
      wait_rise();
      // R7: edge that raises the marker still carries the previous frame's last bit
      check(sdata == 1'b0, "R7", "bit under marker rise", 256'(sdata), 256'h0);
      // R8: disturb inputs right after capture; frame must not change
      drive(i, 1'b1);
      capture(cap, serr);
      check_frame(i, cap, serr);
    end

    // mid-frame reset, then a fresh frame
    repeat (37) @(negedge bit_clk);
    rst_n = 1'b0;
    #1;
    check(sync == 1'b0 && sdata == 1'b0, "R1", "outputs after mid-frame reset", 256'({sync, sdata}), 256'h0);
    drive(1, 1'b0);
    @(negedge bit_clk);
    rst_n = 1'b1;
    @(negedge bit_clk);
    check(sync == 1'b1, "R2", "marker after second release", 256'(sync), 256'h1);
    drive(3, 1'b0); // R8: ignored until the next frame start
    capture(cap, serr);
    check_frame(1, cap, serr);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule